// File: doc/BRIEF.md
# Two-Level 32-Bit Page Table Walker with Large-Page Support

This block turns a 32-bit virtual address into the leaf entry of a two-level page table. A walk starts with one `start` pulse that carries the virtual address, the root frame, the large-page enable and an address mask. The walker first fetches one 4-byte entry from the first-level table. When that entry maps a 4 MB page, the walk stops there. Otherwise the walker fetches a second 4-byte entry from the second-level table. All fetches go through a request/response memory port that allows only one request at a time.

At the end of a walk the block pulses `done` for one cycle. Along with it, it returns one of these outcomes:
- a not-present fault,
- a reserved-bit fault,
- a successful leaf. This gives the leaf entry widened to 40 bits, the address the leaf was read from, the page size and the combined user/writable rights.

For a 4 MB leaf, entry bits 20:13 supply physical bits 39:32 of the page base. On the 4 KB path, a first-level entry whose accessed flag is clear is written back with the flag set before the second-level fetch. Final permission checks and accessed/dirty updates on the leaf itself are left to the logic downstream.

Top module: `pw32_walker`

## Requirements
- R1: The first-level entry address is `{root_base[31:12], 12'h000} + 4*vaddr[31:22]`. The second-level entry address is `{first_entry[31:12], 12'h000} + 4*vaddr[21:12]`. Every address is ANDed with `a20_mask` before it is issued.
- R2: If bit 0 (present) of the first-level entry is clear, the walk ends with `fault_np`=1 and no other memory request is made.
- R3: A 4 MB leaf is taken only when the first-level entry has bit 7 set and `pse_en`=1. In that case no second-level fetch happens, `page_4m`=1, and `leaf_entry` = `{entry[20:13], entry}`.
- R4: On the 4 MB path, an entry with bit 21 set ends the walk with `fault_rsvd`=1 and `page_4m`=1.
- R5: If bit 7 is set but `pse_en`=0, the walk continues to the second level as a 4 KB walk.
- R6: On the 4 KB path, if bit 5 (accessed) of the first-level entry is clear, a write of the entry with bit 5 set goes to the first-level address before the second-level read. If bit 5 is already set, no write is issued.
- R7: If bit 0 of the second-level entry is clear, the walk ends with `fault_np`=1.
- R8: On a 4 KB leaf, `perm_user` is the AND of bit 2 of both entries and `perm_write` is the AND of bit 1 of both entries. On a 4 MB leaf, these two outputs take bits 2 and 1 of the single entry. `perm_exec`=1 on every successful walk and 0 on a fault.
- R9: A 4 KB walk applies no reserved-bit check. Bit 21 set in either entry still gives a good leaf, with `leaf_entry` = the second-level entry zero-extended.
- R10: `leaf_addr` is the address of the last entry read. `done` lasts one cycle. A held request keeps its address and data until it is accepted. No read is issued while another is unanswered. A `start` pulse while `busy`=1 is ignored.
- R11: While `rst_n` is low, and afterwards until a start, `busy`, `done` and `mem_req_valid` are 0. An asserted reset in the middle of a walk abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken when idle) |
| vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Root table pointer; low 12 bits ignored |
| pse_en | input | 1 | Enables 4 MB leaves |
| a20_mask | input | 32 | AND mask applied to every entry address |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Write data (first-level entry with accessed set) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry |
| done | output | 1 | One-cycle completion pulse |
| fault_np | output | 1 | Not-present fault |
| fault_rsvd | output | 1 | Reserved-bit fault on a 4 MB entry |
| page_4m | output | 1 | Leaf is (or would be) a 4 MB page |
| perm_user | output | 1 | Combined user right |
| perm_write | output | 1 | Combined writable right |
| perm_exec | output | 1 | Execute allowed (1 on success) |
| leaf_entry | output | 40 | Leaf entry, widened |
| leaf_addr | output | 32 | Address of the last entry read |

## Verification
The checker has three assumptions about its environment:
- `a20_mask` stays unchanged from `start` until `done`.
- Memory gives exactly one response for each accepted read.
- Writes are never answered.

Its address-mask and outstanding-read properties depend on these assumptions. The bench holds every walk input steady until `done`. Its memory model returns read data one cycle after acceptance and never replies to a write. During reset it drops any pending reply, so a walk cut short by reset leaves no stray response behind. The `start` pulse sent during a busy walk changes only `vaddr` and leaves the mask alone.

// File: rtl/pw32_pkg.sv
package pw32_pkg;

  // entry flag positions; the walker and downstream decode these
  localparam int PW_P      = 0;
  localparam int PW_RW     = 1;
  localparam int PW_US     = 2;
  localparam int PW_A      = 5;
  localparam int PW_PS     = 7;
  localparam int PW_EXT_LO = 13;
  localparam int PW_RSV4M  = 21;

  typedef enum logic [2:0] {
    PW_IDLE   = 3'd0,
    PW_RD_DIR = 3'd1,
    PW_WT_DIR = 3'd2,
    PW_WB_DIR = 3'd3,
    PW_RD_TBL = 3'd4,
    PW_WT_TBL = 3'd5,
    PW_FIN    = 3'd6
  } pw_state_e;

endpackage

// File: rtl/pw32_addr_gen.sv
module pw32_addr_gen #(
  parameter int DW       = 32,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 10
) (
  input  logic [DW-PG_SHIFT-1:0] root_frame,
  input  logic [DW-PG_SHIFT-1:0] tbl_frame,
  input  logic [DW-PG_SHIFT-1:0] vpn,
  input  logic [DW-1:0]          a20_mask,
  output logic [DW-1:0]          dir_addr,
  output logic [DW-1:0]          tbl_addr
);
  localparam int VPN_W  = DW - PG_SHIFT;
  localparam int ENT_SH = 2;
  localparam int PAD    = DW - IDX_W - ENT_SH;

  logic [DW-1:0] dir_base, tbl_base, dir_off, tbl_off;

  assign dir_base = {root_frame, {PG_SHIFT{1'b0}}};
  assign tbl_base = {tbl_frame, {PG_SHIFT{1'b0}}};
  assign dir_off  = {{PAD{1'b0}}, vpn[VPN_W-1 -: IDX_W], {ENT_SH{1'b0}}};
  assign tbl_off  = {{PAD{1'b0}}, vpn[IDX_W-1:0], {ENT_SH{1'b0}}};

  assign dir_addr = (dir_base + dir_off) & a20_mask;
  assign tbl_addr = (tbl_base + tbl_off) & a20_mask;
endmodule

// File: rtl/pw32_entry_dec.sv
module pw32_entry_dec
  import pw32_pkg::*;
#(
  parameter int DW = 32,
  parameter int EW = 40
) (
  input  logic [DW-1:0] entry,
  input  logic          pse_en,
  output logic          present,
  output logic          accessed,
  output logic          big,
  output logic          rsvd_big,
  output logic          user,
  output logic          writable,
  output logic [EW-1:0] wide
);
  localparam int HI = EW - DW;

  assign present  = entry[PW_P];
  assign accessed = entry[PW_A];
  assign big      = entry[PW_P] & entry[PW_PS] & pse_en;
  assign rsvd_big = entry[PW_RSV4M];
  assign user     = entry[PW_US];
  assign writable = entry[PW_RW];

  generate
    if (HI > 0) begin : g_widen
      assign wide = {entry[PW_EXT_LO +: HI], entry};
    end else begin : g_plain
      assign wide = entry;
    end
  endgenerate
endmodule

// File: rtl/pw32_ctrl.sv
module pw32_ctrl
  import pw32_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      req_ready,
  input  logic      rsp_valid,
  input  logic      present,
  input  logic      big,
  input  logic      rsvd_big,
  input  logic      accessed,
  output pw_state_e state_q,
  output logic      ld_req,
  output logic      take_dir,
  output logic      oc_np,
  output logic      oc_rsvd,
  output logic      oc_big,
  output logic      oc_small
);
  pw_state_e state_d;

  always_comb begin
    state_d  = state_q;
    ld_req   = 1'b0;
    take_dir = 1'b0;
    oc_np    = 1'b0;
    oc_rsvd  = 1'b0;
    oc_big   = 1'b0;
    oc_small = 1'b0;
    case (state_q)
      PW_IDLE: begin
        if (start) begin
          ld_req  = 1'b1;
          state_d = PW_RD_DIR;
        end
      end
      PW_RD_DIR: if (req_ready) state_d = PW_WT_DIR;
      PW_WT_DIR: begin
        if (rsp_valid) begin
          take_dir = 1'b1;
          if (!present) begin
            oc_np   = 1'b1;
            state_d = PW_FIN;
          end else if (big) begin
            oc_rsvd = rsvd_big;
            oc_big  = !rsvd_big;
            state_d = PW_FIN;
          end else if (!accessed) begin
            state_d = PW_WB_DIR;
          end else begin
            state_d = PW_RD_TBL;
          end
        end
      end
      PW_WB_DIR: if (req_ready) state_d = PW_RD_TBL;
      PW_RD_TBL: if (req_ready) state_d = PW_WT_TBL;
      PW_WT_TBL: begin
        if (rsp_valid) begin
          oc_np    = !present;
          oc_small = present;
          state_d  = PW_FIN;
        end
      end
      PW_FIN:  state_d = PW_IDLE;
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PW_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pw32_walker.sv
module pw32_walker
  import pw32_pkg::*;
#(
  parameter int DW       = 32,
  parameter int EW       = 40,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] vaddr,
  input  logic [DW-1:0] root_base,
  input  logic          pse_en,
  input  logic [DW-1:0] a20_mask,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic          fault_np,
  output logic          fault_rsvd,
  output logic          page_4m,
  output logic          perm_user,
  output logic          perm_write,
  output logic          perm_exec,
  output logic [EW-1:0] leaf_entry,
  output logic [DW-1:0] leaf_addr
);
  localparam int FR_W = DW - PG_SHIFT;
  localparam logic [DW-1:0] ACC_SET = DW'(1) << PW_A;

  pw_state_e state_q;
  logic ld_req, take_dir, oc_np, oc_rsvd, oc_big, oc_small, res_en;

  logic [FR_W-1:0] vpn_q, root_q;
  logic            pse_q;
  logic [DW-1:0]   a20_q, dir_q;
  logic [DW-1:0]   dir_addr, tbl_addr;

  logic          d_present, d_accessed, d_big, d_rsvd, d_user, d_writable;
  logic [EW-1:0] d_wide;

  logic          np_d, rsvd_d, big_d, user_d, write_d, exec_d;
  logic [EW-1:0] ent_d;
  logic [DW-1:0] addr_d;
  logic          np_q, rsvd_q, big_q, user_q, write_q, exec_q;
  logic [EW-1:0] ent_q;
  logic [DW-1:0] addr_q;

  pw32_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid),
    .present  (d_present),
    .big      (d_big),
    .rsvd_big (d_rsvd),
    .accessed (d_accessed),
    .state_q  (state_q),
    .ld_req   (ld_req),
    .take_dir (take_dir),
    .oc_np    (oc_np),
    .oc_rsvd  (oc_rsvd),
    .oc_big   (oc_big),
    .oc_small (oc_small)
  );

  pw32_addr_gen #(.DW(DW), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W)) u_addr (
    .root_frame(root_q),
    .tbl_frame (dir_q[DW-1:PG_SHIFT]),
    .vpn       (vpn_q),
    .a20_mask  (a20_q),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr)
  );

  pw32_entry_dec #(.DW(DW), .EW(EW)) u_dec (
    .entry   (mem_rsp_data),
    .pse_en  (pse_q),
    .present (d_present),
    .accessed(d_accessed),
    .big     (d_big),
    .rsvd_big(d_rsvd),
    .user    (d_user),
    .writable(d_writable),
    .wide    (d_wide)
  );

  // memory port
  assign busy          = (state_q != PW_IDLE);
  assign done          = (state_q == PW_FIN);
  assign mem_req_valid = (state_q == PW_RD_DIR) || (state_q == PW_WB_DIR) ||
                         (state_q == PW_RD_TBL);
  assign mem_req_write = (state_q == PW_WB_DIR);
  assign mem_req_addr  = (state_q == PW_RD_TBL) ? tbl_addr : dir_addr;
  assign mem_req_wdata = (state_q == PW_WB_DIR) ? (dir_q | ACC_SET) : '0;

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      root_q <= '0;
      pse_q  <= 1'b0;
      a20_q  <= '0;
    end else if (ld_req) begin
      vpn_q  <= vaddr[DW-1:PG_SHIFT];
      root_q <= root_base[DW-1:PG_SHIFT];
      pse_q  <= pse_en;
      a20_q  <= a20_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_q <= '0;
    else if (take_dir) dir_q <= mem_rsp_data;
  end

  // result next values
  assign res_en = oc_np | oc_rsvd | oc_big | oc_small;

  always_comb begin
    np_d    = oc_np;
    rsvd_d  = oc_rsvd;
    big_d   = oc_big | oc_rsvd;
    exec_d  = oc_big | oc_small;
    user_d  = 1'b0;
    write_d = 1'b0;
    ent_d   = '0;
    if (oc_big) begin
      user_d  = d_user;
      write_d = d_writable;
      ent_d   = d_wide;
    end else if (oc_small) begin
      user_d  = d_user & dir_q[PW_US];
      write_d = d_writable & dir_q[PW_RW];
      ent_d   = EW'(mem_rsp_data);
    end
    addr_d = (state_q == PW_WT_TBL) ? tbl_addr : dir_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      np_q    <= 1'b0;
      rsvd_q  <= 1'b0;
      big_q   <= 1'b0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      exec_q  <= 1'b0;
      ent_q   <= '0;
      addr_q  <= '0;
    end else if (res_en) begin
      np_q    <= np_d;
      rsvd_q  <= rsvd_d;
      big_q   <= big_d;
      user_q  <= user_d;
      write_q <= write_d;
      exec_q  <= exec_d;
      ent_q   <= ent_d;
      addr_q  <= addr_d;
    end
  end

  assign fault_np   = np_q;
  assign fault_rsvd = rsvd_q;
  assign page_4m    = big_q;
  assign perm_user  = user_q;
  assign perm_write = write_q;
  assign perm_exec  = exec_q;
  assign leaf_entry = ent_q;
  assign leaf_addr  = addr_q;
endmodule

// File: rtl/pw32_walker_chk.sv
module pw32_walker_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] a20_mask,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [DW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic          fault_np,
  input logic          fault_rsvd,
  input logic          page_4m,
  input logic          perm_exec
);
  logic [1:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write && !mem_rsp_valid)
      open_q <= open_q + 2'd1;
    else if (mem_rsp_valid && !(mem_req_valid && mem_req_ready && !mem_req_write))
      open_q <= open_q - 2'd1;
  end

  p_addr_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_addr & ~a20_mask) == '0));
  p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  p_fault_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(fault_np && fault_rsvd));
  p_rsvd_big_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_rsvd) |-> page_4m);
  p_wb_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[5] && mem_req_wdata[0]));
  p_exec_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (perm_exec == !(fault_np || fault_rsvd)));
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (open_q == 2'd0));
  p_rsp_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (open_q == 2'd1));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !done));
endmodule

bind pw32_walker pw32_walker_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .a20_mask     (a20_mask),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .fault_np     (fault_np),
  .fault_rsvd   (fault_rsvd),
  .page_4m      (page_4m),
  .perm_exec    (perm_exec)
);

// File: tb/tb_pw32_walker.sv
`timescale 1ns/1ps
module tb_pw32_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, pse_en;
  logic [31:0] vaddr, root_base, a20_mask;
  logic        busy, mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done, fault_np, fault_rsvd, page_4m, perm_user, perm_write, perm_exec;
  logic [39:0] leaf_entry;
  logic [31:0] leaf_addr;

  pw32_walker dut (.*);

  typedef struct packed {
    logic [31:0] va, root, a20, pde, pte;
    logic        pse, x_np, x_rsvd, x_4m, x_us, x_rw;
    logic [39:0] x_ent;
    logic [1:0]  x_rd;
    logic        x_wb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h12345678, 32'h00100abc, 32'hFFFFFFFF, 32'h00200007, 32'h00300067, 1'b1,
      1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 40'h0000300067, 2'd2, 1'b1},
    '{32'h80000000, 32'h00100000, 32'hFFFFFFFF, 32'h00200006, 32'h0,        1'b1,
      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h0,          2'd1, 1'b0},
    '{32'hC0401000, 32'h00200000, 32'hFFFFFFFF, 32'h004B40A7, 32'h0,        1'b1,
      1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 40'h5A004B40A7, 2'd1, 1'b0},
    '{32'h00400000, 32'h00300000, 32'hFFFFFFFF, 32'h00600083, 32'h0,        1'b1,
      1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40'h0,          2'd1, 1'b0},
    '{32'h00801000, 32'h00100000, 32'hFFFFFFFF, 32'h007000A5, 32'h00800003, 1'b0,
      1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h0000800003, 2'd2, 1'b0},
    '{32'hFFFFF000, 32'h00100000, 32'hFFFFFFFF, 32'h00200027, 32'h00300002, 1'b1,
      1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h0,          2'd2, 1'b0},
    '{32'h3FF00FFC, 32'h00500000, 32'hFFFFFFFF, 32'h00A00027, 32'h00E00005, 1'b1,
      1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 40'h0000E00005, 2'd2, 1'b0},
    '{32'h00000000, 32'h00100000, 32'hFFEFFFFF, 32'h00100023, 32'h00000007, 1'b1,
      1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 40'h0000000007, 2'd2, 1'b0}
  };

  int total = 0, fail = 0;
  int rd_cnt, wr_cnt, wr_seq, cyc = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] wr_addr, wr_data, cur_pde, cur_pte, rsp_dat;
  logic rsp_pend = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  endtask

  // memory model: one reply per accepted read, one cycle later
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!rst_n) begin
        rsp_pend = 1'b0;
      end else begin
        if (rsp_pend) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_dat;
          rsp_pend      = 1'b0;
        end
        cyc++;
        mem_req_ready = (cyc % 3) != 1;
        if (mem_req_valid && mem_req_ready) begin
          if (mem_req_write) begin
            wr_cnt++;
            wr_addr = mem_req_addr;
            wr_data = mem_req_wdata;
            wr_seq  = rd_cnt;
          end else begin
            if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
            rsp_dat  = (rd_cnt == 0) ? cur_pde : cur_pte;
            rd_cnt++;
            rsp_pend = 1'b1;
          end
        end
      end
    end
  end

  task automatic run_vec(input int i, input bit poke);
    vec_t v;
    logic [31:0] x_dir, x_tbl, x_leaf;
    bit got;
    v = VEC[i];
    cur_pde = v.pde; cur_pte = v.pte;
    rd_cnt = 0; wr_cnt = 0; wr_seq = 0;
    @(negedge clk);
    start = 1'b1; vaddr = v.va; root_base = v.root; pse_en = v.pse; a20_mask = v.a20;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int c = 0; c < 200 && !got; c++) begin
      if (done) got = 1'b1;
      else begin
        if (poke && c == 2) begin start = 1'b1; vaddr = 32'hFFFFFFFF; end
        else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    if (!got) begin
      chk($sformatf("R10 walk %0d completes", i), 0, 1);
      return;
    end
    x_dir  = ({v.root[31:12], 12'h000} + {20'h0, v.va[31:22], 2'b00}) & v.a20;
    x_tbl  = ({v.pde[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00}) & v.a20;
    x_leaf = (v.x_rd == 2'd2) ? x_tbl : x_dir;
    chk($sformatf("R2/R7 fault_np v%0d", i), fault_np, v.x_np);
    chk($sformatf("R4 fault_rsvd v%0d", i), fault_rsvd, v.x_rsvd);
    chk($sformatf("R3/R5 page_4m v%0d", i), page_4m, v.x_4m);
    chk($sformatf("R8 rights v%0d", i), {perm_user, perm_write, perm_exec},
        {v.x_us, v.x_rw, !(v.x_np || v.x_rsvd)});
    chk($sformatf("R3/R9 leaf_entry v%0d", i), leaf_entry, v.x_ent);
    chk($sformatf("R10 leaf_addr v%0d", i), leaf_addr, x_leaf);
    chk($sformatf("R1 first address v%0d", i), rd_addr[0], x_dir);
    chk($sformatf("R2/R3 read count v%0d", i), rd_cnt, v.x_rd);
    if (v.x_rd == 2'd2) chk($sformatf("R1/R5 second address v%0d", i), rd_addr[1], x_tbl);
    if (v.x_wb) begin
      chk($sformatf("R6 writeback v%0d", i), {wr_cnt, wr_addr, wr_data, wr_seq},
          {32'd1, x_dir, v.pde | 32'h20, 32'd1});
    end else begin
      chk($sformatf("R6 no writeback v%0d", i), wr_cnt, 0);
    end
    @(negedge clk);
    chk($sformatf("R10 done single cycle v%0d", i), done, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pse_en = 1'b0;
    vaddr = '0; root_base = '0; a20_mask = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    chk("R11 reset quiet", {busy, done, mem_req_valid, fault_np, perm_exec}, 5'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 idle after reset", {busy, done, mem_req_valid}, 3'b0);

    // table of walks
    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

    // start while busy is ignored: results match vector 0
    run_vec(0, 1'b1);
    chk("R10 busy start ignored", rd_cnt, 2);

    // reset in the middle of a walk
    cur_pde = VEC[0].pde; cur_pte = VEC[0].pte; rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    start = 1'b1; vaddr = VEC[0].va; root_base = VEC[0].root; pse_en = 1'b1;
    a20_mask = 32'hFFFFFFFF;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid-walk reset", {busy, done, mem_req_valid}, 3'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 stays idle after abort", {busy, mem_req_valid}, 2'b0);

    // normal walk after the abort
    run_vec(2, 1'b0);
    finish_run();
  end
endmodule